// File: doc/BRIEF.md
# NAND Flash Byte Access Sequencer

This block runs one byte-wide transfer on an 8-bit NAND flash bus. The transfer is a command byte, an address byte, a data read or a data write. A host asserts a request with the access kind, the byte to send and four timing fields. The block then steps through three phases: a setup phase, a strobe phase and a hold phase. It drives chip select, the read and write strobes, the two latch-enable lines and the data bus, which has a separate output enable. It acknowledges the host once the access has finished.

The four timing fields set the setup length, the minimum strobe length, the hold length and a bus-float delay for driven accesses. The strobe phase also waits for the flash ready/busy line. The higher-level command and address sequence is built by the host one access at a time. Any number of address accesses may follow each other.

Top module: `nand_access_seq`

## Requirements
- R1: During reset and after reset, with no request, the block is idle: `nf_ce_n`, `nf_re_n` and `nf_we_n` are high, and `nf_ale`, `nf_cle`, `nf_dq_oe` and `ack` are low.
- R2: `req_kind` encodes 0 = command, 1 = address, 2 = data read and 3 = data write. `nf_cle` is high for the whole of a command access and `nf_ale` for the whole of an address access. Both are low for data accesses and in idle.
- R3: A request is accepted at a clock edge while the block is idle. The setup phase begins in the next cycle and lasts max(`cfg_setup`,1) cycles. During setup `nf_ce_n` is low and both strobes are high.
- R4: The strobe phase lasts at least max(`cfg_strobe`,1)+1 cycles. In this phase `nf_re_n` is low for a read and `nf_we_n` is low for the other kinds. The two strobes are never low together.
- R5: The strobe phase ends only in a cycle where its minimum length has been reached and `nf_rb` is sampled high. While `nf_rb` is low the strobe stays asserted.
- R6: The hold phase follows the strobe phase and lasts `cfg_hold` cycles, clamped to the range 1..254. Both strobes are high, while `nf_ce_n`, the latch enables and the driven byte keep their values.
- R7: For command, address and write accesses, `nf_dq_oe` is low during the first `cfg_float` cycles of the access, counted from the first setup cycle. It is then high until the end of the hold phase, with `nf_dq_o` equal to the requested byte. A read access never drives the bus.
- R8: On a read, `nf_dq_i` is captured in the last cycle of the strobe phase. It appears on `rd_data` and stays there until a later read replaces it.
- R9: `ack` is high for exactly the one cycle that follows the hold phase. In that cycle `nf_ce_n` is high again.
- R10: Requests arriving during an access are ignored. The kind, byte and timing fields are taken only at acceptance, so changes to them during an access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | Access kind (0 cmd, 1 addr, 2 read, 3 write) |
| req_wdata | input | 8 | Byte to drive for command, address and write accesses |
| cfg_setup | input | 8 | Setup phase length |
| cfg_strobe | input | 8 | Strobe length minus one |
| cfg_hold | input | 8 | Hold phase length |
| cfg_float | input | 8 | Cycles the bus floats at the start of a driven access |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte captured by a read |
| nf_ce_n | output | 1 | Chip select, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_ale | output | 1 | Address latch enable |
| nf_cle | output | 1 | Command latch enable |
| nf_dq_o | output | 8 | Data bus output value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_i | input | 8 | Data bus input value |
| nf_rb | input | 1 | Ready/busy from the flash, low when busy |

## Verification
The assertions assume that `nf_rb` is a clean synchronous level, and that `nf_dq_i` is stable at the edge that closes the strobe phase. The bench changes these inputs only at falling clock edges, so both assumptions hold. The assertions do not depend on the host waiting for `ack`. To exercise R10, the stimulus keeps `req_valid` high and inverts every request field for the whole access. It releases `req_valid` only in the acknowledge cycle. The sweep covers every kind and several short timing settings, plus single cases for clamped fields, a long busy period and a float delay longer than the access.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_READ  = 2'd2,
    KIND_WRITE = 2'd3
  } nfs_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } nfs_phase_e;
endpackage

// File: rtl/nfs_req_latch.sv
module nfs_req_latch
  import nfs_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned TW       = 8,
  parameter int unsigned HOLD_MAX = 254
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          busy,
  input  nfs_kind_e     kind_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] strobe_i,
  input  logic [TW-1:0] hold_i,
  input  logic [TW-1:0] float_i,
  output logic [TW-1:0] setup_ld_nx,
  output logic [TW-1:0] strobe_ld_q,
  output logic [TW-1:0] hold_ld_q,
  output nfs_kind_e     kind_q,
  output nfs_kind_e     kind_nx,
  output logic [DW-1:0] wdata_nx,
  output logic [TW-1:0] float_nx
);
  localparam logic [TW-1:0] ONE_T  = TW'(1);
  localparam logic [TW-1:0] HMAX_T = TW'(HOLD_MAX);

  logic [TW-1:0] strobe_norm, hold_norm;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] float_q;

  always_comb begin
    setup_ld_nx = (setup_i == '0) ? '0 : setup_i - ONE_T;
    strobe_norm = (strobe_i == '0) ? ONE_T : strobe_i;
    if (hold_i == '0)          hold_norm = '0;
    else if (hold_i > HMAX_T)  hold_norm = HMAX_T - ONE_T;
    else                       hold_norm = hold_i - ONE_T;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= KIND_CMD;
      wdata_q     <= '0;
      float_q     <= '0;
      strobe_ld_q <= ONE_T;
      hold_ld_q   <= '0;
    end else if (accept) begin
      kind_q      <= kind_i;
      wdata_q     <= wdata_i;
      float_q     <= float_i;
      strobe_ld_q <= strobe_norm;
      hold_ld_q   <= hold_norm;
    end
  end

  assign kind_nx  = accept ? kind_i  : kind_q;
  assign wdata_nx = accept ? wdata_i : wdata_q;
  assign float_nx = accept ? float_i : float_q;

  // R10
  held_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> ($stable(kind_q) && $stable(wdata_q) && $stable(hold_ld_q)));
endmodule

// File: rtl/nfs_phase_ctrl.sv
module nfs_phase_ctrl
  import nfs_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          rb,
  input  logic [TW-1:0] setup_ld_nx,
  input  logic [TW-1:0] strobe_ld,
  input  logic [TW-1:0] hold_ld,
  output logic          accept,
  output logic          strobe_last,
  output nfs_phase_e    phase_q,
  output nfs_phase_e    phase_d,
  output logic          ack
);
  localparam logic [TW-1:0] ONE_T = TW'(1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          ack_d;

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    accept      = 1'b0;
    strobe_last = 1'b0;
    ack_d       = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          phase_d = PH_SETUP;
          cnt_d   = setup_ld_nx;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = strobe_ld;
        end else begin
          cnt_d = cnt_q - ONE_T;
        end
      end
      PH_STROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - ONE_T;
        end else if (rb) begin
          strobe_last = 1'b1;
          phase_d     = PH_HOLD;
          cnt_d       = hold_ld;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          ack_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE_T;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ack     <= ack_d;
    end
  end

  // R5
  busy_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STROBE && !rb) |=> (phase_q == PH_STROBE));
  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R9
  ack_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (phase_q == PH_IDLE && $past(phase_q) == PH_HOLD));
endmodule

// File: rtl/nfs_pin_drv.sv
module nfs_pin_drv
  import nfs_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          strobe_last,
  input  nfs_phase_e    phase_d,
  input  nfs_kind_e     kind_q,
  input  nfs_kind_e     kind_nx,
  input  logic [DW-1:0] wdata_nx,
  input  logic [TW-1:0] float_nx,
  input  logic [DW-1:0] dq_i,
  output logic          ce_n,
  output logic          re_n,
  output logic          we_n,
  output logic          ale,
  output logic          cle,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [DW-1:0] rd_data
);
  localparam logic [TW-1:0] SAT_T = '1;
  localparam logic [TW-1:0] ONE_T = TW'(1);

  logic [TW-1:0] elapsed_q, elapsed_d;
  logic          active_d, strobe_d, drives_d;

  always_comb begin
    if (accept)                elapsed_d = '0;
    else if (elapsed_q == SAT_T) elapsed_d = SAT_T;
    else                       elapsed_d = elapsed_q + ONE_T;
    active_d = (phase_d != PH_IDLE);
    strobe_d = (phase_d == PH_STROBE);
    drives_d = active_d && (kind_nx != KIND_READ) && (elapsed_d >= float_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= SAT_T;
      ce_n      <= 1'b1;
      re_n      <= 1'b1;
      we_n      <= 1'b1;
      ale       <= 1'b0;
      cle       <= 1'b0;
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      rd_data   <= '0;
    end else begin
      elapsed_q <= elapsed_d;
      ce_n      <= !active_d;
      re_n      <= !(strobe_d && kind_nx == KIND_READ);
      we_n      <= !(strobe_d && kind_nx != KIND_READ);
      ale       <= active_d && kind_nx == KIND_ADDR;
      cle       <= active_d && kind_nx == KIND_CMD;
      dq_oe     <= drives_d;
      if (active_d) dq_o <= wdata_nx;
      if (strobe_last && kind_q == KIND_READ) rd_data <= dq_i;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!re_n && !we_n));
  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ale && cle));
  // R7
  read_float_chk: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);
  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (re_n && we_n && !ale && !cle && !dq_oe));
endmodule

// File: rtl/nand_access_seq.sv
module nand_access_seq
  import nfs_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned TW       = 8,
  parameter int unsigned HOLD_MAX = 254
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_strobe,
  input  logic [TW-1:0] cfg_hold,
  input  logic [TW-1:0] cfg_float,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic          nf_ce_n,
  output logic          nf_re_n,
  output logic          nf_we_n,
  output logic          nf_ale,
  output logic          nf_cle,
  output logic [DW-1:0] nf_dq_o,
  output logic          nf_dq_oe,
  input  logic [DW-1:0] nf_dq_i,
  input  logic          nf_rb
);
  logic          accept, strobe_last;
  nfs_phase_e    phase_q, phase_d;
  nfs_kind_e     kind_q, kind_nx;
  logic [DW-1:0] wdata_nx;
  logic [TW-1:0] float_nx, setup_ld_nx, strobe_ld_q, hold_ld_q;

  nfs_req_latch #(.DW(DW), .TW(TW), .HOLD_MAX(HOLD_MAX)) u_latch (
    .clk(clk), .rst(rst), .accept(accept), .busy(phase_q != PH_IDLE),
    .kind_i(nfs_kind_e'(req_kind)), .wdata_i(req_wdata),
    .setup_i(cfg_setup), .strobe_i(cfg_strobe), .hold_i(cfg_hold), .float_i(cfg_float),
    .setup_ld_nx(setup_ld_nx), .strobe_ld_q(strobe_ld_q), .hold_ld_q(hold_ld_q),
    .kind_q(kind_q), .kind_nx(kind_nx), .wdata_nx(wdata_nx), .float_nx(float_nx)
  );

  nfs_phase_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .rb(nf_rb),
    .setup_ld_nx(setup_ld_nx), .strobe_ld(strobe_ld_q), .hold_ld(hold_ld_q),
    .accept(accept), .strobe_last(strobe_last),
    .phase_q(phase_q), .phase_d(phase_d), .ack(ack)
  );

  nfs_pin_drv #(.DW(DW), .TW(TW)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .strobe_last(strobe_last),
    .phase_d(phase_d), .kind_q(kind_q), .kind_nx(kind_nx),
    .wdata_nx(wdata_nx), .float_nx(float_nx), .dq_i(nf_dq_i),
    .ce_n(nf_ce_n), .re_n(nf_re_n), .we_n(nf_we_n), .ale(nf_ale), .cle(nf_cle),
    .dq_o(nf_dq_o), .dq_oe(nf_dq_oe), .rd_data(rd_data)
  );

  // R3
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nf_ce_n) |-> (nf_re_n && nf_we_n));
endmodule

// File: tb/nand_access_seq_bench.sv
`timescale 1ns/1ps
module nand_access_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_wdata = 8'd0, cfg_setup = 8'd1, cfg_strobe = 8'd1, cfg_hold = 8'd1, cfg_float = 8'd0;
  logic [7:0] nf_dq_i = 8'd0;
  logic       nf_rb = 1'b1;
  logic       ack, nf_ce_n, nf_re_n, nf_we_n, nf_ale, nf_cle, nf_dq_oe;
  logic [7:0] rd_data, nf_dq_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  nand_access_seq u_nand_access_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_float(cfg_float),
    .ack(ack), .rd_data(rd_data), .nf_ce_n(nf_ce_n), .nf_re_n(nf_re_n), .nf_we_n(nf_we_n),
    .nf_ale(nf_ale), .nf_cle(nf_cle), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pat(input int k, input int seed);
    return (k * 29 + seed * 7 + 13) & 255;
  endfunction

  // One access; rbl = cycles from access start during which nf_rb is low
  task automatic run(input int kind, input int wd, input int sf, input int wf,
                     input int hf, input int ff, input int rbl);
    int s, wv, h, e, last;
    s  = (sf == 0) ? 1 : sf;
    wv = (wf == 0) ? 1 : wf;
    h  = (hf == 0) ? 1 : ((hf > 254) ? 254 : hf);
    e  = s + wv;
    if (rbl > e) e = rbl;
    last = e + h + 1;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_wdata = 8'(wd);
    cfg_setup = 8'(sf); cfg_strobe = 8'(wf); cfg_hold = 8'(hf); cfg_float = 8'(ff);
    nf_rb = 1'b1;
    for (int k = 0; k <= last; k++) begin
      bit in_acc, in_stb, drv;
      @(negedge clk);
      nf_rb   = (k >= rbl);
      nf_dq_i = 8'(pat(k, sf + wf));
      if (k < last) begin
        // R10: garbage request and fields during the access
        req_valid = 1'b1; req_kind = ~2'(kind); req_wdata = ~8'(wd);
        cfg_setup = ~8'(sf); cfg_strobe = ~8'(wf); cfg_hold = ~8'(hf); cfg_float = ~8'(ff);
      end else begin
        req_valid = 1'b0;
      end
      in_acc = (k < last);
      in_stb = (k >= s) && (k <= e);
      drv    = in_acc && (kind != 2) && (k >= ff);
      chk("R3/R9 ce_n", nf_ce_n, !in_acc);
      chk("R4/R5 re_n", nf_re_n, !(in_stb && kind == 2));
      chk("R4/R5/R6 we_n", nf_we_n, !(in_stb && kind != 2));
      chk("R2 ale", nf_ale, in_acc && kind == 1);
      chk("R2 cle", nf_cle, in_acc && kind == 0);
      chk("R7 dq_oe", nf_dq_oe, drv);
      if (drv) chk("R7/R10 dq_o", nf_dq_o, wd & 255);
      chk("R9 ack", ack, k == last);
    end
    @(negedge clk);
    chk("R9 ack drop", ack, 0);
    chk("R9 ce idle", nf_ce_n, 1);
    if (kind == 2) chk("R8 rd_data", rd_data, pat(e, sf + wf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ce_n", nf_ce_n, 1);
    chk("R1 re_n", nf_re_n, 1);
    chk("R1 we_n", nf_we_n, 1);
    chk("R1 ale/cle", {nf_ale, nf_cle}, 0);
    chk("R1 dq_oe", nf_dq_oe, 0);
    chk("R1 ack", ack, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {nf_ce_n, nf_re_n, nf_we_n, ack}, 4'b1110);
    for (int kd = 0; kd < 4; kd++)
      for (int sf = 1; sf <= 3; sf++)
        for (int wf = 1; wf <= 3; wf++)
          for (int hf = 1; hf <= 2; hf++)
            for (int fi = 0; fi < 2; fi++)
              run(kd, 8'h5A ^ (kd * 17 + sf * 3 + wf), sf, wf, hf, fi * 3, 0);
    // R5 long busy during strobe, both strobe kinds
    run(2, 8'h00, 2, 2, 1, 0, 15);
    run(3, 8'hC3, 1, 1, 2, 1, 9);
    // R5 busy only during setup has no effect
    run(0, 8'h70, 4, 2, 1, 0, 3);
    // R3/R4/R6 clamped fields
    run(1, 8'h11, 0, 0, 0, 0, 0);
    run(3, 8'h22, 1, 1, 255, 2, 0);
    run(2, 8'h00, 0, 0, 0, 0, 0);
    // R7 float longer than the access: bus never driven
    run(3, 8'h99, 2, 2, 2, 200, 0);
    // Back-to-back address accesses
    run(1, 8'h01, 1, 1, 1, 0, 0);
    run(1, 8'h02, 1, 1, 1, 0, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule